// File: doc/BRIEF.md
# Noise-Adaptive Decoder Strength Controller

This controller sits beside an iterative error-correcting decoder and decides, at a fixed cadence, how strong the decoder should be. It counts the bits the decoder accepts. When a sampling window of `WINDOW_BITS` bits is complete, it reads the current channel quality estimate and maps it to a decoder strength code through a small table that software or a neighbouring block can rewrite. A noisy channel (low quality figure) maps to a large strength code for stronger correction. A clean channel maps to a small code, which saves power.

A new decoder image is requested only when the chosen code differs from the one that is loaded now. Loading a new image takes a long time. During that interval the controller ignores incoming bits and waits for a completion pulse. The loaded-code register changes only when that pulse arrives. Counting then resumes from zero.

Top module: `snr_reconfig_ctrl`

## Requirements
- R1: Reset behaviour. After reset, `cur_nmax` and `cfg_nmax` both equal `PWRON_NMAX` (default 5), and `cfg_req` is 0.
- R2: Window timing. An evaluation starts once `WINDOW_BITS` `bit_valid` pulses have been accepted while counting. The evaluation reads `snr_est` in the cycle after the pulse that completes the window. `cfg_req` can rise only in the second cycle after that pulse, never earlier in the window.
- R3: Table lookup. The selected code comes from the lowest-indexed table entry i for which `snr_est` < threshold[i]. If no entry matches, the default code is selected.
- R4: Change-only requests. `cfg_req` is a one-cycle pulse, and it is raised only when the selected code differs from `cur_nmax`. When the two are equal, counting resumes with no request.
- R5: Request target. From the request cycle until the completion pulse, `cfg_nmax` carries the selected code, and `cur_nmax` keeps its old value.
- R6: Completion handling. `cur_nmax` takes the value of `cfg_nmax` in the cycle after `cfg_done` is seen while waiting. A `cfg_done` seen in any other state has no effect.
- R7: Bit handling outside counting. `bit_valid` pulses during evaluation, request or waiting are not counted. After completion, the next window needs a full `WINDOW_BITS` fresh pulses.
- R8: Table writes. With `tbl_we` high:
  - index i < `ENTRIES` writes threshold[i] = `tbl_thresh` and code[i] = `tbl_code`;
  - index `ENTRIES` writes the default code from `tbl_code`;
  - any larger index changes nothing.
- R9: Reset table contents. After reset, threshold[i] = (i+1)·2^(SNR_W-3), which is 32, 64, 96 and 128 for 8-bit estimates. The codes are code[i] = ENTRIES+1-i (5, 4, 3, 2), and the default code is 1. A lower quality figure therefore selects a larger code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | One decoded bit accepted this cycle |
| snr_est | input | SNR_W | Channel quality estimate, larger means cleaner |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | clog2(ENTRIES+1) | Table entry index; ENTRIES selects the default code |
| tbl_thresh | input | SNR_W | Threshold value to write |
| tbl_code | input | NMAX_W | Strength code to write |
| cfg_done | input | 1 | Pulse: the new decoder image is loaded |
| cfg_req | output | 1 | Pulse: load the image for `cfg_nmax` |
| cfg_nmax | output | NMAX_W | Strength code requested or last selected |
| cur_nmax | output | NMAX_W | Strength code currently loaded |

## Verification
The embedded properties watch the following on every cycle:
- the counter never moves while it is disabled and never passes its terminal value;
- a completed window is always followed by an evaluation;
- a request is a single-cycle pulse that appears only when the selected and loaded codes differ;
- the loaded code and the request target stay still except at their defined update points;
- out-of-range table writes leave the table untouched.

Some behaviours need the bench's scenarios. These are: whether the lookup picks the right entry at exact threshold boundaries, whether a spurious completion pulse during the request cycle is ignored, and whether bits arriving outside counting shift the next window's end. The bench shows these by comparing the request timing and the codes against its own table model, over random tables and directed boundary values.

// File: rtl/snr_reconfig_pkg.sv
package snr_reconfig_pkg;

  typedef enum logic [1:0] {
    ST_COUNT = 2'd0,
    ST_EVAL  = 2'd1,
    ST_REQ   = 2'd2,
    ST_WAIT  = 2'd3
  } ctrl_state_t;

endpackage

// File: rtl/snr_bit_window.sv
module snr_bit_window #(
  parameter int WINDOW_BITS = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bit_valid,
  input  logic clr,
  output logic window_end
);

  localparam int CNT_W = $clog2(WINDOW_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_BITS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             take_bit;

  assign take_bit   = en && bit_valid;
  assign window_end = take_bit && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else if (take_bit) begin
      cnt_q <= window_end ? '0 : cnt_q + 1'b1;
    end
  end

  // R7: counter is frozen whenever counting is disabled
  p_count_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cnt_q));

  // R2: the count never passes the window's terminal value
  p_count_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/snr_nmax_table.sv
module snr_nmax_table #(
  parameter int ENTRIES = 4,
  parameter int SNR_W   = 8,
  parameter int NMAX_W  = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [$clog2(ENTRIES+1)-1:0]      wr_idx,
  input  logic [SNR_W-1:0]                  wr_thresh,
  input  logic [NMAX_W-1:0]                 wr_code,
  input  logic [SNR_W-1:0]                  snr,
  output logic [NMAX_W-1:0]                 sel_code
);

  localparam int IDX_W = $clog2(ENTRIES + 1);

  logic [ENTRIES-1:0][SNR_W-1:0]  thr_q;
  logic [ENTRIES-1:0][NMAX_W-1:0] code_q;
  logic [NMAX_W-1:0]              dflt_q;
  logic                           bad_write;

  function automatic logic [SNR_W-1:0] reset_thresh(input int i);
    return SNR_W'((i + 1) << (SNR_W - 3));
  endfunction

  function automatic logic [NMAX_W-1:0] reset_code(input int i);
    return NMAX_W'(ENTRIES + 1 - i);
  endfunction

  // First entry (lowest index) whose threshold lies above the estimate wins.
  function automatic logic [NMAX_W-1:0] first_above(
    input logic [ENTRIES-1:0][SNR_W-1:0]  th,
    input logic [ENTRIES-1:0][NMAX_W-1:0] cd,
    input logic [NMAX_W-1:0]              dflt,
    input logic [SNR_W-1:0]               s
  );
    logic [NMAX_W-1:0] r;
    logic              hit;
    r   = dflt;
    hit = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!hit && (s < th[i])) begin
        r   = cd[i];
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  assign sel_code  = first_above(thr_q, code_q, dflt_q, snr);
  assign bad_write = wr_en && (int'(wr_idx) > ENTRIES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        thr_q[i]  <= reset_thresh(i);
        code_q[i] <= reset_code(i);
      end
      dflt_q <= NMAX_W'(1);
    end else if (wr_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_idx == IDX_W'(i)) begin
          thr_q[i]  <= wr_thresh;
          code_q[i] <= wr_code;
        end
      end
      if (wr_idx == IDX_W'(ENTRIES)) begin
        dflt_q <= wr_code;
      end
    end
  end

  // R8: a write beyond the default slot leaves the whole table unchanged
  p_bad_index_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_write |=> ($stable(thr_q) && $stable(code_q) && $stable(dflt_q)));

  // R8: with no write strobe the table holds
  p_table_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(thr_q) && $stable(code_q) && $stable(dflt_q)));

endmodule

// File: rtl/snr_reconfig_fsm.sv
module snr_reconfig_fsm
  import snr_reconfig_pkg::*;
#(
  parameter int NMAX_W     = 4,
  parameter int PWRON_NMAX = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              window_end,
  input  logic [NMAX_W-1:0] sel_code,
  input  logic              cfg_done,
  output logic              cnt_en,
  output logic              cnt_clr,
  output logic              cfg_req,
  output logic [NMAX_W-1:0] target,
  output logic [NMAX_W-1:0] cur
);

  ctrl_state_t       state_q;
  logic [NMAX_W-1:0] target_q;
  logic [NMAX_W-1:0] cur_q;
  logic              code_changed;
  logic              reconf_finish;

  assign code_changed  = (sel_code != cur_q);
  assign reconf_finish = (state_q == ST_WAIT) && cfg_done;
  assign cnt_en        = (state_q == ST_COUNT);
  assign cnt_clr       = reconf_finish;
  assign cfg_req       = (state_q == ST_REQ);
  assign target        = target_q;
  assign cur           = cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_COUNT;
      target_q <= NMAX_W'(PWRON_NMAX);
      cur_q    <= NMAX_W'(PWRON_NMAX);
    end else begin
      unique case (state_q)
        ST_COUNT: if (window_end) state_q <= ST_EVAL;
        ST_EVAL: begin
          target_q <= sel_code;
          state_q  <= code_changed ? ST_REQ : ST_COUNT;
        end
        ST_REQ:   state_q <= ST_WAIT;
        ST_WAIT: begin
          if (cfg_done) begin
            cur_q   <= target_q;
            state_q <= ST_COUNT;
          end
        end
        default:  state_q <= ST_COUNT;
      endcase
    end
  end

  // R2: a completed window always leads to an evaluation
  p_eval_follows_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    window_end |=> (state_q == ST_EVAL));

  // R4: a request is only ever raised for a code that differs from the loaded one
  p_req_only_on_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (target_q != cur_q));

  // R4: request lasts one cycle and is followed by waiting
  p_req_single_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |=> (!cfg_req && state_q == ST_WAIT));

  // R6: loaded code moves only on a completion seen while waiting
  p_cur_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !reconf_finish |=> $stable(cur_q));

  // R5: request target is written only by an evaluation
  p_target_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_EVAL) |=> $stable(target_q));

endmodule

// File: rtl/snr_reconfig_ctrl.sv
module snr_reconfig_ctrl #(
  parameter int WINDOW_BITS = 250000,
  parameter int SNR_W       = 8,
  parameter int NMAX_W      = 4,
  parameter int ENTRIES     = 4,
  parameter int PWRON_NMAX  = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bit_valid,
  input  logic [SNR_W-1:0]              snr_est,
  input  logic                          tbl_we,
  input  logic [$clog2(ENTRIES+1)-1:0]  tbl_idx,
  input  logic [SNR_W-1:0]              tbl_thresh,
  input  logic [NMAX_W-1:0]             tbl_code,
  input  logic                          cfg_done,
  output logic                          cfg_req,
  output logic [NMAX_W-1:0]             cfg_nmax,
  output logic [NMAX_W-1:0]             cur_nmax
);

  logic              cnt_en;
  logic              cnt_clr;
  logic              window_end;
  logic [NMAX_W-1:0] sel_code;

  snr_bit_window #(.WINDOW_BITS(WINDOW_BITS)) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (cnt_en),
    .bit_valid  (bit_valid),
    .clr        (cnt_clr),
    .window_end (window_end)
  );

  snr_nmax_table #(.ENTRIES(ENTRIES), .SNR_W(SNR_W), .NMAX_W(NMAX_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (tbl_we),
    .wr_idx    (tbl_idx),
    .wr_thresh (tbl_thresh),
    .wr_code   (tbl_code),
    .snr       (snr_est),
    .sel_code  (sel_code)
  );

  snr_reconfig_fsm #(.NMAX_W(NMAX_W), .PWRON_NMAX(PWRON_NMAX)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .window_end (window_end),
    .sel_code   (sel_code),
    .cfg_done   (cfg_done),
    .cnt_en     (cnt_en),
    .cnt_clr    (cnt_clr),
    .cfg_req    (cfg_req),
    .target     (cfg_nmax),
    .cur        (cur_nmax)
  );

endmodule

// File: tb/tb_snr_reconfig_ctrl.sv
module tb_snr_reconfig_ctrl;

  localparam int WIN = 16;
  localparam int SW  = 8;
  localparam int NW  = 4;
  localparam int NE  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bit_valid = 1'b0;
  logic [SW-1:0] snr_est = '0;
  logic          tbl_we = 1'b0;
  logic [2:0]    tbl_idx = '0;
  logic [SW-1:0] tbl_thresh = '0;
  logic [NW-1:0] tbl_code = '0;
  logic          cfg_done = 1'b0;
  logic          cfg_req;
  logic [NW-1:0] cfg_nmax;
  logic [NW-1:0] cur_nmax;

  int n_chk = 0;
  int n_fail = 0;
  int m_thr[NE];
  int m_code[NE];
  int m_dflt;
  int m_cur;

  always #2 clk = ~clk;

  snr_reconfig_ctrl #(.WINDOW_BITS(WIN), .SNR_W(SW), .NMAX_W(NW), .ENTRIES(NE),
                      .PWRON_NMAX(5)) dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .snr_est(snr_est),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_thresh(tbl_thresh), .tbl_code(tbl_code),
    .cfg_done(cfg_done), .cfg_req(cfg_req), .cfg_nmax(cfg_nmax), .cur_nmax(cur_nmax)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Expected selection, from the table rule of R3
  function automatic int expect_code(input int s);
    for (int i = 0; i < NE; i++) begin
      if (s < m_thr[i]) return m_code[i];
    end
    return m_dflt;
  endfunction

  task automatic write_entry(input int idx, input int th, input int cd);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 3'(idx); tbl_thresh = SW'(th); tbl_code = NW'(cd);
    @(negedge clk);
    tbl_we = 1'b0;
    if (idx < NE) begin
      m_thr[idx] = th; m_code[idx] = cd;
    end else if (idx == NE) begin
      m_dflt = cd;
    end
  endtask

  // One full window at estimate s; spurious_done pulses cfg_done during the request cycle
  task automatic run_window(input int s, input bit spurious_done);
    int exp_code;
    bit early;
    early = 1'b0;
    exp_code = expect_code(s);
    @(negedge clk);
    snr_est = SW'(s);
    for (int k = 0; k < WIN; k++) begin
      for (int g = 0; g < int'($urandom % 3); g++) begin
        @(negedge clk);
        bit_valid = 1'b0;
        if (cfg_req) early = 1'b1;
      end
      @(negedge clk);
      bit_valid = 1'b1;
      if (cfg_req) early = 1'b1;
    end
    @(negedge clk);                     // evaluation cycle
    bit_valid = (exp_code == m_cur);    // R7: a bit here must not be counted
    if (cfg_req) early = 1'b1;
    check("R2 no request inside window", int'(early), 0);
    @(negedge clk);                     // request cycle
    bit_valid = 1'b0;
    check("R4 request only on change", int'(cfg_req), int'(exp_code != m_cur));
    check("R3 selected code", int'(cfg_nmax), exp_code);
    if (exp_code != m_cur) begin
      cfg_done = spurious_done;         // R6: ignored outside waiting
      @(negedge clk);
      cfg_done = 1'b0;
      for (int w = 0; w < 1 + int'($urandom % 5); w++) begin
        bit_valid = 1'($urandom);       // R7: bits while waiting are ignored
        @(negedge clk);
        check("R5 loaded code held while waiting", int'(cur_nmax), m_cur);
      end
      bit_valid = 1'b0;
      check("R5 target held while waiting", int'(cfg_nmax), exp_code);
      cfg_done = 1'b1;
      @(negedge clk);
      cfg_done = 1'b0;
      check("R6 loaded code after completion", int'(cur_nmax), exp_code);
      check("R4 request is one pulse", int'(cfg_req), 0);
      m_cur = exp_code;
    end else begin
      check("R4 loaded code unchanged without request", int'(cur_nmax), m_cur);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NE; i++) begin
      m_thr[i]  = (i + 1) << (SW - 3);
      m_code[i] = NE + 1 - i;
    end
    m_dflt = 1;
    m_cur  = 5;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 loaded code at reset", int'(cur_nmax), 5);
    check("R1 target at reset", int'(cfg_nmax), 5);
    check("R1 no request at reset", int'(cfg_req), 0);

    // R9: reset table, including exact threshold boundaries
    run_window(10, 1'b0);
    run_window(250, 1'b1);
    run_window(40, 1'b0);
    run_window(32, 1'b0);
    run_window(31, 1'b1);
    run_window(127, 1'b0);
    run_window(128, 1'b0);

    // R8: out-of-range writes change nothing
    write_entry(NE + 1, 3, 9);
    write_entry(7, 0, 0);
    run_window(200, 1'b0);
    run_window(0, 1'b0);

    // R8: rewrite the table with random ascending thresholds
    for (int r = 0; r < 6; r++) begin
      int t;
      t = 0;
      for (int i = 0; i < NE; i++) begin
        t = t + 1 + int'($urandom % 55);
        if (t > 255) t = 255;
        write_entry(i, t, 1 + int'($urandom % 15));
      end
      write_entry(NE, 0, int'($urandom % 16));
      run_window(m_thr[0] - 1 < 0 ? 0 : m_thr[0] - 1, 1'b1);
      run_window(m_thr[NE-1], 1'b0);
      for (int n = 0; n < 4; n++) begin
        run_window(int'($urandom % 256), 1'($urandom));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R2: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule